// File: doc/BRIEF.md
# Way-Locking Victim Selector

This block chooses which way of a set-associative cache receives a new line on a miss. Software can pin a number of ways so that they are never replaced. The lock count is a plain input, and pinned ways are taken from the highest-numbered way downward. The remaining ways are shared by a per-set round-robin pointer. When every way is pinned, the block returns no victim and raises a bypass flag. The miss is then served without allocation.

A second path loads a pinned way with the contents software wants kept there. A flush command names a way, a set, a tag and a fetch flag. The block drives one tag-memory write carrying the tag with its valid bit set. If the fetch flag was given, it then holds a line-fetch request until memory reports completion, and it stays busy for that whole time.

Top module: `way_lock_victim_sel`

## Requirements
- R1: After reset, victim_valid_o, no_alloc_o, busy_o, tag_we_o and fetch_req_o are low. Every set's pointer is 0, so the first miss on any set yields way 0.
- R2: A miss sampled at a clock edge gives exactly one of victim_valid_o or no_alloc_o high in the following cycle. That output lasts one cycle, and both outputs are low when no miss was sampled.
- R3: With lock count L below NUM_WAYS, victim_way_o is always below NUM_WAYS-L. The top L ways are never returned.
- R4: Successive victims for one set follow 0, 1, ..., U-1, 0, where U = NUM_WAYS-L. Each set keeps its own pointer.
- R5: If a set's pointer is at or above U because L has risen, that set's next victim is way 0.
- R6: A lock count at or above NUM_WAYS (any value of the 3-bit field from 4 to 7 in the default build) gives no_alloc_o instead of a victim and leaves the set's pointer unchanged.
- R7: A flush accepted while idle gives a tag_we_o pulse of exactly one cycle in the next cycle. The pulse carries the flush way and set, and tag_wdata_o = {1'b1, tag}, with the valid bit as the MSB.
- R8: When the fetch flag is set, fetch_req_o rises after the tag write and holds, with fetch_set_o and fetch_tag_o stable, until fetch_done_i is sampled. busy_o stays high from the cycle after acceptance through that cycle.
- R9: When the fetch flag is clear, busy_o is high for exactly the one tag-write cycle.
- R10: A flush request presented while busy_o is high is ignored. It produces no tag write and does not change the tag held.
- R11: fetch_done_i is ignored while no fetch is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_cnt_i | input | LCNT_W | Number of pinned ways, counted from the top way |
| miss_valid_i | input | 1 | Miss needing a victim |
| miss_set_i | input | SET_W | Set index of the miss |
| victim_valid_o | output | 1 | victim_way_o is valid |
| victim_way_o | output | WAY_W | Chosen way |
| no_alloc_o | output | 1 | All ways pinned; serve the miss uncached |
| flush_valid_i | input | 1 | Flush command |
| flush_way_i | input | WAY_W | Way to load |
| flush_set_i | input | SET_W | Set to load |
| flush_tag_i | input | TAG_W | Tag to install |
| flush_fetch_i | input | 1 | Also fetch the line data |
| busy_o | output | 1 | Flush in progress |
| tag_we_o | output | 1 | Tag-memory write strobe |
| tag_way_o | output | WAY_W | Tag write way |
| tag_set_o | output | SET_W | Tag write set |
| tag_wdata_o | output | TAG_W+1 | {valid, tag} |
| fetch_req_o | output | 1 | Line-fetch request |
| fetch_set_o | output | SET_W | Fetch set |
| fetch_tag_o | output | TAG_W | Fetch tag |
| fetch_done_i | input | 1 | Fetch complete |

## Verification
The bench targets pointer wraparound at the unlocked boundary. A selector that wrapped at NUM_WAYS instead of U would hand out a pinned way. It raises the lock count while a set's pointer already sits in the pinned region, where a design without the reset-to-zero rule would return a locked way. It applies lock counts of four and seven, where a design without clamping would wrap the subtraction and allocate. It also presents flush requests during a pending fetch and completion pulses while idle, which a weak handshake would turn into a second tag write or a stuck busy flag.

// File: rtl/wls_pkg.sv
package wls_pkg;
  typedef enum logic [1:0] {
    FL_IDLE  = 2'd0,
    FL_WRITE = 2'd1,
    FL_FETCH = 2'd2
  } flush_st_e;
endpackage

// File: rtl/wls_rr_state.sv
module wls_rr_state #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] rd_ptr_o,
  input  logic             upd_i,
  input  logic [SET_W-1:0] upd_set_i,
  input  logic [WAY_W-1:0] upd_ptr_i
);
  logic [WAY_W-1:0] ptr_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ptr_q[s] <= '0;
      else if (upd_i && upd_set_i == SET_W'(s))     ptr_q[s] <= upd_ptr_i;
    end
  end

  always_comb begin
    rd_ptr_o = '0;
    for (int s = 0; s < NUM_SETS; s++)
      if (rd_set_i == SET_W'(s)) rd_ptr_o = ptr_q[s];
  end
endmodule

// File: rtl/wls_victim_pick.sv
module wls_victim_pick #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int LCNT_W = $clog2(NUM_WAYS + 1)
) (
  input  logic [WAY_W-1:0]  ptr_i,
  input  logic [LCNT_W-1:0] lock_cnt_i,
  output logic              has_victim_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [WAY_W-1:0]  next_ptr_o
);
  logic [LCNT_W-1:0] unlocked;
  logic [LCNT_W-1:0] inc;
  logic [WAY_W-1:0]  base;

  always_comb begin
    // clamp: counts above NUM_WAYS mean everything is pinned
    unlocked = (lock_cnt_i >= LCNT_W'(NUM_WAYS)) ? '0
             : LCNT_W'(NUM_WAYS) - lock_cnt_i;
    has_victim_o = (unlocked != '0);
    // pointer left in the pinned region restarts at way 0
    base = (LCNT_W'(ptr_i) < unlocked) ? ptr_i : '0;
    inc  = LCNT_W'(base) + LCNT_W'(1);
    way_o = base;
    if (!has_victim_o)        next_ptr_o = ptr_i;
    else if (inc >= unlocked) next_ptr_o = '0;
    else                      next_ptr_o = WAY_W'(inc);
  end
endmodule

// File: rtl/wls_flush_ctrl.sv
module wls_flush_ctrl
  import wls_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter int TAG_W    = 8,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_valid_i,
  input  logic [WAY_W-1:0] flush_way_i,
  input  logic [SET_W-1:0] flush_set_i,
  input  logic [TAG_W-1:0] flush_tag_i,
  input  logic             flush_fetch_i,
  output logic             busy_o,
  output logic             tag_we_o,
  output logic [WAY_W-1:0] tag_way_o,
  output logic [SET_W-1:0] tag_set_o,
  output logic [TAG_W:0]   tag_wdata_o,
  output logic             fetch_req_o,
  output logic [SET_W-1:0] fetch_set_o,
  output logic [TAG_W-1:0] fetch_tag_o,
  input  logic             fetch_done_i
);
  flush_st_e        st_q, st_d;
  logic [WAY_W-1:0] way_q;
  logic [SET_W-1:0] set_q;
  logic [TAG_W-1:0] tag_q;
  logic             fetch_q;
  logic             accept;

  assign accept = flush_valid_i && (st_q == FL_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FL_IDLE:  if (accept)       st_d = FL_WRITE;
      FL_WRITE: st_d = fetch_q ? FL_FETCH : FL_IDLE;
      FL_FETCH: if (fetch_done_i) st_d = FL_IDLE;
      default:  st_d = FL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FL_IDLE;
      way_q   <= '0;
      set_q   <= '0;
      tag_q   <= '0;
      fetch_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        way_q   <= flush_way_i;
        set_q   <= flush_set_i;
        tag_q   <= flush_tag_i;
        fetch_q <= flush_fetch_i;
      end
    end
  end

  assign busy_o      = (st_q != FL_IDLE);
  assign tag_we_o    = (st_q == FL_WRITE);
  assign tag_way_o   = way_q;
  assign tag_set_o   = set_q;
  assign tag_wdata_o = {1'b1, tag_q};
  assign fetch_req_o = (st_q == FL_FETCH);
  assign fetch_set_o = set_q;
  assign fetch_tag_o = tag_q;

  p_tag_we_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |=> !tag_we_o);
  p_fetch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !fetch_done_i) |=> (fetch_req_o && $stable(fetch_tag_o) && $stable(fetch_set_o)));
  p_busy_covers_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> busy_o);
  p_ignore_while_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(tag_wdata_o));
  p_done_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !flush_valid_i) |=> !busy_o);
endmodule

// File: rtl/way_lock_victim_sel.sv
module way_lock_victim_sel #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter int TAG_W    = 8,
  localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int LCNT_W = $clog2(NUM_WAYS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LCNT_W-1:0] lock_cnt_i,
  input  logic              miss_valid_i,
  input  logic [SET_W-1:0]  miss_set_i,
  output logic              victim_valid_o,
  output logic [WAY_W-1:0]  victim_way_o,
  output logic              no_alloc_o,
  input  logic              flush_valid_i,
  input  logic [WAY_W-1:0]  flush_way_i,
  input  logic [SET_W-1:0]  flush_set_i,
  input  logic [TAG_W-1:0]  flush_tag_i,
  input  logic              flush_fetch_i,
  output logic              busy_o,
  output logic              tag_we_o,
  output logic [WAY_W-1:0]  tag_way_o,
  output logic [SET_W-1:0]  tag_set_o,
  output logic [TAG_W:0]    tag_wdata_o,
  output logic              fetch_req_o,
  output logic [SET_W-1:0]  fetch_set_o,
  output logic [TAG_W-1:0]  fetch_tag_o,
  input  logic              fetch_done_i
);
  logic [WAY_W-1:0] cur_ptr, nxt_ptr, pick_way;
  logic             has_victim;

  wls_rr_state #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) i_rr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_set_i  (miss_set_i),
    .rd_ptr_o  (cur_ptr),
    .upd_i     (miss_valid_i && has_victim),
    .upd_set_i (miss_set_i),
    .upd_ptr_i (nxt_ptr)
  );

  wls_victim_pick #(.NUM_WAYS(NUM_WAYS)) i_pick (
    .ptr_i        (cur_ptr),
    .lock_cnt_i   (lock_cnt_i),
    .has_victim_o (has_victim),
    .way_o        (pick_way),
    .next_ptr_o   (nxt_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_valid_o <= 1'b0;
      no_alloc_o     <= 1'b0;
      victim_way_o   <= '0;
    end else begin
      victim_valid_o <= miss_valid_i && has_victim;
      no_alloc_o     <= miss_valid_i && !has_victim;
      if (miss_valid_i) victim_way_o <= pick_way;
    end
  end

  wls_flush_ctrl #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) i_flush (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_valid_i (flush_valid_i),
    .flush_way_i   (flush_way_i),
    .flush_set_i   (flush_set_i),
    .flush_tag_i   (flush_tag_i),
    .flush_fetch_i (flush_fetch_i),
    .busy_o        (busy_o),
    .tag_we_o      (tag_we_o),
    .tag_way_o     (tag_way_o),
    .tag_set_o     (tag_set_o),
    .tag_wdata_o   (tag_wdata_o),
    .fetch_req_o   (fetch_req_o),
    .fetch_set_o   (fetch_set_o),
    .fetch_tag_o   (fetch_tag_o),
    .fetch_done_i  (fetch_done_i)
  );

  p_one_result_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(victim_valid_o && no_alloc_o));
  p_result_needs_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (victim_valid_o || no_alloc_o) |-> $past(miss_valid_i));
  p_victim_unlocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> (LCNT_W'(victim_way_o) + $past(lock_cnt_i) < LCNT_W'(NUM_WAYS)));
  p_no_alloc_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_alloc_o |-> ($past(lock_cnt_i) >= LCNT_W'(NUM_WAYS)));
endmodule

// File: tb/test_way_lock_victim_sel.sv
`timescale 1ns/1ps
module test_way_lock_victim_sel;
  localparam int NV = 20;
  // {set[3:0], lock[2:0], no_alloc, way[1:0]}
  localparam bit [9:0] VECS [NV] = '{
    {4'd0, 3'd0, 1'b0, 2'd0}, {4'd0, 3'd0, 1'b0, 2'd1},
    {4'd0, 3'd0, 1'b0, 2'd2}, {4'd0, 3'd0, 1'b0, 2'd3},
    {4'd0, 3'd0, 1'b0, 2'd0}, {4'd1, 3'd0, 1'b0, 2'd0},
    {4'd0, 3'd1, 1'b0, 2'd1}, {4'd0, 3'd1, 1'b0, 2'd2},
    {4'd0, 3'd1, 1'b0, 2'd0}, {4'd1, 3'd2, 1'b0, 2'd1},
    {4'd1, 3'd2, 1'b0, 2'd0}, {4'd0, 3'd0, 1'b0, 2'd1},
    {4'd0, 3'd0, 1'b0, 2'd2}, {4'd0, 3'd2, 1'b0, 2'd0},
    {4'd0, 3'd3, 1'b0, 2'd0}, {4'd0, 3'd3, 1'b0, 2'd0},
    {4'd0, 3'd4, 1'b1, 2'd0}, {4'd0, 3'd7, 1'b1, 2'd0},
    {4'd0, 3'd0, 1'b0, 2'd0}, {4'd2, 3'd1, 1'b0, 2'd0}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] lock_cnt = '0;
  logic       miss_valid = 1'b0;
  logic [3:0] miss_set = '0;
  logic       victim_valid, no_alloc;
  logic [1:0] victim_way;
  logic       flush_valid = 1'b0, flush_fetch = 1'b0, fetch_done = 1'b0;
  logic [1:0] flush_way = '0;
  logic [3:0] flush_set = '0;
  logic [7:0] flush_tag = '0;
  logic       busy, tag_we, fetch_req;
  logic [1:0] tag_way;
  logic [3:0] tag_set, fetch_set;
  logic [8:0] tag_wdata;
  logic [7:0] fetch_tag;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  way_lock_victim_sel i_way_lock_victim_sel (
    .clk_i(clk), .rst_ni(rst_n), .lock_cnt_i(lock_cnt),
    .miss_valid_i(miss_valid), .miss_set_i(miss_set),
    .victim_valid_o(victim_valid), .victim_way_o(victim_way), .no_alloc_o(no_alloc),
    .flush_valid_i(flush_valid), .flush_way_i(flush_way), .flush_set_i(flush_set),
    .flush_tag_i(flush_tag), .flush_fetch_i(flush_fetch), .busy_o(busy),
    .tag_we_o(tag_we), .tag_way_o(tag_way), .tag_set_o(tag_set), .tag_wdata_o(tag_wdata),
    .fetch_req_o(fetch_req), .fetch_set_o(fetch_set), .fetch_tag_o(fetch_tag),
    .fetch_done_i(fetch_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 victim_valid", victim_valid, 0);
    chk("R1 no_alloc", no_alloc, 0);
    chk("R1 busy", busy, 0);
    chk("R1 tag_we", tag_we, 0);
    chk("R1 fetch_req", fetch_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle", {victim_valid, no_alloc}, 0);

    for (int i = 0; i < NV; i++) begin
      string tg;
      miss_valid = 1'b1;
      miss_set   = VECS[i][9:6];
      lock_cnt   = VECS[i][5:3];
      @(negedge clk);
      tg = VECS[i][2] ? "R6" : ((i == 13 || i == 14) ? "R5" : "R4");
      chk(tg, {victim_valid, no_alloc}, VECS[i][2] ? 2'b01 : 2'b10);
      if (!VECS[i][2]) begin
        chk(tg, victim_way, VECS[i][1:0]);
        chk("R3", (3'(victim_way) + lock_cnt) < 3'd4, 1);
      end
    end
    miss_valid = 1'b0;
    @(negedge clk);
    chk("R2 pulse", {victim_valid, no_alloc}, 0);

    // R9 flush without fetch
    flush_valid = 1'b1; flush_way = 2'd3; flush_set = 4'd5; flush_tag = 8'hA5; flush_fetch = 1'b0;
    @(negedge clk);
    flush_valid = 1'b0;
    chk("R7 tag_we", tag_we, 1);
    chk("R7 way", tag_way, 3);
    chk("R7 set", tag_set, 5);
    chk("R7 data", tag_wdata, 9'h1A5);
    chk("R9 busy", busy, 1);
    chk("R9 no fetch", fetch_req, 0);
    @(negedge clk);
    chk("R9 busy end", busy, 0);
    chk("R7 single", tag_we, 0);

    // R8 flush with fetch, R10 request during busy
    flush_valid = 1'b1; flush_way = 2'd2; flush_set = 4'd9; flush_tag = 8'h3C; flush_fetch = 1'b1;
    @(negedge clk);
    chk("R7 tag_we", tag_we, 1);
    chk("R7 data", tag_wdata, 9'h13C);
    flush_way = 2'd1; flush_tag = 8'h77; flush_set = 4'd2;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 fetch_req", fetch_req, 1);
      chk("R8 fetch_set", fetch_set, 9);
      chk("R8 fetch_tag", fetch_tag, 8'h3C);
      chk("R8 busy", busy, 1);
      chk("R10 no write", tag_we, 0);
    end
    flush_valid = 1'b0;
    chk("R10 tag kept", tag_wdata, 9'h13C);
    fetch_done = 1'b1;
    @(negedge clk);
    fetch_done = 1'b0;
    chk("R8 done busy", busy, 0);
    chk("R8 done req", fetch_req, 0);
    @(negedge clk);
    chk("R10 no late write", tag_we, 0);

    // R11 stray completion
    fetch_done = 1'b1;
    @(negedge clk);
    fetch_done = 1'b0;
    chk("R11 busy", busy, 0);
    chk("R11 req", fetch_req, 0);
    chk("R11 we", tag_we, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule